// File: doc/BRIEF.md
# Period/Duty PWM Generator

A stand-alone pulse-width modulator with a 16-bit up-counter, a period (cycle) register and a duty register, all reached through an 8-bit register bus. The counter runs from zero up to the cycle value and then starts again. The output goes high at every restart and goes low once the counter reaches the duty value. Software sets the period and the high time byte by byte, picks a clock divide of 1, 2, 4 or 8, and can ask for an interrupt at the end of every period.

Period and duty values are held in working copies that reload only when the counter restarts, so a period that is running keeps its shape while new values are written. Three duty and cycle combinations have fixed results: a duty of zero gives a steady low, a duty of all ones gives a steady high, and a cycle value at or below the duty value also gives a steady high. While the enable bit is clear, the counter and divider stay at zero and the output stays low.

Top module: `pwm_period_duty`

## Requirements
- R1: After reset, every readable register returns 00h, `pwm_out` is low and `irq` is low.
- R2: With the block enabled, the counter steps by one on each divider tick. On the tick where it equals the working cycle value it goes back to 0, and this is a restart. Offset 5 returns counter bits 15:8 and offset 6 returns bits 7:0.
- R3: Control bits 3:2 set the divide. Values 0, 1, 2 and 3 give a counter tick every 1, 2, 4 and 8 clocks.
- R4: For a working cycle value above the duty value, `pwm_out` is high while the counter is below the duty value and low from the duty value to the end of the period.
- R5: A working duty of 0000h keeps `pwm_out` low whatever the cycle value.
- R6: A working duty of FFFFh keeps `pwm_out` high.
- R7: A working cycle value less than or equal to the working duty value keeps `pwm_out` high.
- R8: While the block is enabled, a duty write (offsets 1 high, 2 low) or a cycle write (offsets 3 high, 4 low) takes effect only at the next restart. While it is disabled, the write takes effect at once.
- R9: While control bit 0 (enable) is clear, the counter reads 0, the divider is held, and `pwm_out` is low.
- R10: Control bit 7 is a pending flag. Every restart sets it. A control write with bit 7 = 1 clears it, and a write with bit 7 = 0 leaves it unchanged. A restart in the same cycle wins over a clear.
- R11: `irq` is high exactly when the pending flag and control bit 1 (interrupt enable) are both set.
- R12: Reads are combinational on the bus address. Offset 0 returns control with the pending flag in bit 7, offsets 1 to 4 return the programmed duty and cycle bytes, offsets 5 and 6 return the counter, and offset 7 returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a duty or cycle write that lands in the middle of a running period. The old period has to finish unchanged, and the new values have to take over exactly at the restart. The bench reaches this by enabling the generator and then writing new duty and cycle bytes at arbitrary counter values, while a behavioural model compares the output, the interrupt and the counter readback on every clock. The divide settings, the clear of the pending flag while disabled, and the three fixed-level duty cases are each set up from a disabled state, so the working copies load before counting starts.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int ADDR_W = 3;
  // register offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DUTY_H = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DUTY_L = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CYC_H  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CYC_L  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CNT_H  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_CNT_L  = 3'd6;
  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_IE    = 1;
  localparam int CB_PS_LO = 2;

  // terminal count of the divider for a given select value
  function automatic int unsigned div_terminal(input int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler import pwm_gen_pkg::*; #(
  parameter int PS_W = 2,
  localparam int DIV_W = (2 ** PS_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_lim;

  assign div_lim = DIV_W'(div_terminal(32'(ps)));
  assign tick    = en && (div_q >= div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!en || tick)   div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  // R3: with a divide above 1, two ticks never fall on adjacent clocks
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps != '0) |=> (!tick || ps == '0));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty_prog,
  input  logic [CNT_W-1:0] cyc_prog,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q, duty_a, cyc_a;

  function automatic logic level_of(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] d,
                                    input logic [CNT_W-1:0] p);
    if (d == '0)       return 1'b0;
    if (d == ALL_ONES) return 1'b1;
    if (p <= d)        return 1'b1;
    return c < d;
  endfunction

  assign wrap = tick && (cnt_q == cyc_a);
  assign cnt  = cnt_q;
  assign pwm  = en && level_of(cnt_q, duty_a, cyc_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_a <= '0;
      cyc_a  <= '0;
    end else if (!en || wrap) begin
      cnt_q  <= '0;
      duty_a <= duty_prog;
      cyc_a  <= cyc_prog;
    end else if (tick) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2: counter never passes the working cycle value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt_q <= cyc_a);
  // R2: a restart brings the counter back to zero
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  // R4: output is high right after a restart unless duty is zero or disabled
  p_high_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pwm || !en || duty_a == '0));
  // R8: working copies only change at a restart or while disabled
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(duty_a) && $stable(cyc_a)));
  // R9: disabled holds the counter at zero
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs import pwm_gen_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int PS_W   = 2,
  localparam int CNT_W = 2 * DATA_W,
  localparam int CB_PEND = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              ie,
  output logic [PS_W-1:0]   ps,
  output logic [CNT_W-1:0]  duty,
  output logic [CNT_W-1:0]  cyc,
  output logic              irq
);
  logic pend_q;
  logic ctrl_wr;
  logic unused_wbits;

  assign ctrl_wr      = wr && (addr == OFS_CTRL);
  assign unused_wbits = ^wdata[CB_PEND-1:CB_PS_LO+PS_W];
  assign irq          = pend_q && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ie   <= 1'b0;
      ps   <= '0;
      duty <= '0;
      cyc  <= '0;
    end else if (wr) begin
      case (addr)
        OFS_CTRL: begin
          en <= wdata[CB_EN];
          ie <= wdata[CB_IE];
          ps <= wdata[CB_PS_LO +: PS_W];
        end
        OFS_DUTY_H: duty[DATA_W +: DATA_W] <= wdata;
        OFS_DUTY_L: duty[0 +: DATA_W]      <= wdata;
        OFS_CYC_H:  cyc[DATA_W +: DATA_W]  <= wdata;
        OFS_CYC_L:  cyc[0 +: DATA_W]       <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pend_q <= 1'b0;
    else if (wrap)                      pend_q <= 1'b1;
    else if (ctrl_wr && wdata[CB_PEND]) pend_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[CB_EN]               = en;
        rdata[CB_IE]               = ie;
        rdata[CB_PS_LO +: PS_W]    = ps;
        rdata[CB_PEND]             = pend_q;
      end
      OFS_DUTY_H: rdata = duty[DATA_W +: DATA_W];
      OFS_DUTY_L: rdata = duty[0 +: DATA_W];
      OFS_CYC_H:  rdata = cyc[DATA_W +: DATA_W];
      OFS_CYC_L:  rdata = cyc[0 +: DATA_W];
      OFS_CNT_H:  rdata = cnt[DATA_W +: DATA_W];
      OFS_CNT_L:  rdata = cnt[0 +: DATA_W];
      default:    rdata = '0;
    endcase
  end

  // R10: a restart always leaves the pending flag set
  p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend_q);
  // R10: a write of zero to the flag bit never clears it
  p_pend_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(ctrl_wr && wdata[CB_PEND])) |=> pend_q);
  // R11: no request without the interrupt enable
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);
endmodule

// File: rtl/pwm_period_duty.sv
module pwm_period_duty import pwm_gen_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int PS_W   = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out,
  output logic              irq
);
  logic             en, ie, tick, wrap;
  logic [PS_W-1:0]  ps;
  logic [CNT_W-1:0] duty, cyc, cnt;

  pwm_regs #(.DATA_W(DATA_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .wrap(wrap), .cnt(cnt), .rdata(bus_rdata), .en(en), .ie(ie), .ps(ps),
    .duty(duty), .cyc(cyc), .irq(irq)
  );

  pwm_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .ps(ps), .tick(tick)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .duty_prog(duty),
    .cyc_prog(cyc), .cnt(cnt), .wrap(wrap), .pwm(pwm_out)
  );

  // R1: outputs quiet on the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pwm_out && !irq));
endmodule

// File: tb/sim_pwm_period_duty.sv
`timescale 1ns/1ps
module sim_pwm_period_duty;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd6;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pwm_out, irq;

  always #2.5 clk = ~clk;

  pwm_period_duty u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  int    n_chk = 0, n_err = 0;
  string tag = "R1";
  bit    chk_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference state
  int m_en, m_ie, m_ps, m_pend, m_duty, m_cyc, m_da, m_ca, m_cnt, m_div;

  function automatic int exp_level(int c, int d, int p);
    if (d == 0) return 0;
    if (d == 65535) return 1;
    if (!(p > d)) return 1;
    return (c < d) ? 1 : 0;
  endfunction

  function automatic int exp_read(int a);
    case (a)
      0: return m_en + 2 * m_ie + 4 * m_ps + 128 * m_pend;
      1: return m_duty / 256;
      2: return m_duty % 256;
      3: return m_cyc / 256;
      4: return m_cyc % 256;
      5: return m_cnt / 256;
      6: return m_cnt % 256;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_ps = 0; m_pend = 0; m_duty = 0; m_cyc = 0;
      m_da = 0; m_ca = 0; m_cnt = 0; m_div = 0;
    end else begin
      int step, wrapped, per;
      per = 1;
      repeat (m_ps) per = per * 2;
      step = (m_en != 0) && (m_div + 1 >= per);
      wrapped = step && (m_cnt == m_ca);
      if (m_en == 0) begin
        m_cnt = 0; m_div = 0; m_da = m_duty; m_ca = m_cyc;
      end else begin
        m_div = step ? 0 : m_div + 1;
        if (wrapped) begin m_cnt = 0; m_da = m_duty; m_ca = m_cyc; end
        else if (step) m_cnt = m_cnt + 1;
      end
      if (bus_wr && bus_addr == 0 && bus_wdata[7]) m_pend = 0;
      if (wrapped) m_pend = 1;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_ps = int'(bus_wdata[3:2]); end
          3'd1: m_duty = int'(bus_wdata) * 256 + m_duty % 256;
          3'd2: m_duty = (m_duty / 256) * 256 + int'(bus_wdata);
          3'd3: m_cyc  = int'(bus_wdata) * 256 + m_cyc % 256;
          3'd4: m_cyc  = (m_cyc / 256) * 256 + int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check(tag, "pwm_out", int'(pwm_out), (m_en != 0) ? exp_level(m_cnt, m_da, m_ca) : 0);
      check(tag, "irq", int'(irq), (m_pend != 0 && m_ie != 0) ? 1 : 0);
      check(tag, "bus_rdata", int'(bus_rdata), exp_read(int'(bus_addr)));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d[7:0];
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = 3'd6;
  endtask

  task automatic wr16(int hi_ofs, int v);
    wr(hi_ofs, v / 256);
    wr(hi_ofs + 1, v % 256);
  endtask

  task automatic rd(int a, int exp, string t);
    @(negedge clk); #1;
    bus_addr = a[2:0];
    @(negedge clk);
    check(t, "read", int'(bus_rdata), exp);
    #1 bus_addr = 3'd6;
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  task automatic setup(int duty, int cyc, int ctrl);
    wr(0, 0);
    wr16(1, duty);
    wr16(3, cyc);
    wr(0, ctrl);
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("R1", "pwm_out", int'(pwm_out), 0);
    check("R1", "irq", int'(irq), 0);
    for (int a = 0; a < 7; a++) rd(a, 0, "R1");
    chk_on = 1'b1;

    // R12: register map readback
    tag = "R12";
    wr16(1, 16'h1234);
    wr16(3, 16'hABCD);
    rd(1, 8'h12, "R12"); rd(2, 8'h34, "R12");
    rd(3, 8'hAB, "R12"); rd(4, 8'hCD, "R12"); rd(7, 0, "R12");

    // R2 R4: basic waveform, counter readback
    tag = "R2";
    setup(3, 9, 8'h03);
    repeat (40) @(negedge clk);
    tag = "R4";
    repeat (40) @(negedge clk);

    // R10: pending flag survives a zero write, clears on a one
    tag = "R10";
    wr(0, 8'h02);
    rd(0, 8'h82, "R10");
    check("R10", "irq held", int'(irq), 1);
    wr(0, 8'h82);
    rd(0, 8'h02, "R10");
    check("R10", "irq cleared", int'(irq), 0);

    // R8: mid-period updates wait for the restart
    tag = "R8";
    setup(3, 9, 8'h01);
    repeat (4) @(negedge clk);
    wr16(1, 7);
    repeat (3) @(negedge clk);
    wr16(3, 12);
    repeat (60) @(negedge clk);
    wr16(1, 2);
    repeat (50) @(negedge clk);

    // R3: divider settings
    tag = "R3";
    for (int s = 1; s < 4; s++) begin
      setup(2, 5, 1 + 4 * s);
      repeat (120) @(negedge clk);
    end
    setup(2, 5, 8'h0D);
    count_high(48, h);
    check("R3", "high clocks per period at divide 8", h, 16);

    // R5: zero duty
    tag = "R5";
    setup(0, 5, 8'h01);
    count_high(60, h);
    check("R5", "high clocks", h, 0);

    // R6: full duty
    tag = "R6";
    setup(16'hFFFF, 20, 8'h01);
    count_high(60, h);
    check("R6", "high clocks", h, 60);

    // R7: cycle not above duty
    tag = "R7";
    setup(10, 10, 8'h01);
    count_high(60, h);
    check("R7", "high clocks cyc=duty", h, 60);
    setup(10, 4, 8'h01);
    count_high(60, h);
    check("R7", "high clocks cyc<duty", h, 60);

    // R9: disable holds counter and output
    tag = "R9";
    setup(3, 9, 8'h01);
    repeat (6) @(negedge clk);
    wr(0, 8'h00);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9", "pwm_out", int'(pwm_out), 0);
      check("R9", "count lo", int'(bus_rdata), 0);
    end
    rd(5, 0, "R9");

    // R11: interrupt gating
    tag = "R11";
    setup(3, 9, 8'h81);
    repeat (30) @(negedge clk);
    check("R11", "irq with ie clear", int'(irq), 0);
    wr(0, 8'h03);
    @(negedge clk);
    check("R11", "irq with ie set", int'(irq), 1);
    repeat (20) @(negedge clk);

    chk_on = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule